// File: doc/BRIEF.md
# Asynchronous Serial Port with Byte-Wide Host Interface

This block is a full-duplex asynchronous serial port. A host sees two locations behind one select line. With select low, a write loads the control word and a read returns the status word. With select high, a write hands a character to the transmitter and a read takes the last received character. The control word picks a bit period of 1, 16 or 64 clocks, or holds the port in master reset. It also picks one of eight character formats, sets the request-to-send level together with the transmit interrupt and a forced break, and enables the receive interrupt.

The transmitter sends a low start bit, then the data bits least significant first, then an optional parity bit, then one or two high stop bits. The receiver finds a start edge and samples every following bit once. It checks parity and the first stop bit and flags overrun. Clear-to-send gates the start of a new character. The carrier-detect and clear-to-send inputs can be read in the status word. A single interrupt output combines the receive and transmit conditions.

Top module: `async_serial_port`

## Requirements
- R1: After reset the port is in master reset. The status word reads 0x02 while both modem inputs are low, txd is high, rts is low and irq is low.
- R2: Control bits [1:0] set the bit period: 0 is one clock, 1 is DIV_MID clocks (16 by default) and 2 is DIV_SLOW clocks (64 by default). A transmitted start bit holds txd low for exactly one bit period.
- R3: Control code 3 in bits [1:0] is master reset. It clears receive full, overrun, framing error and parity error, and it empties the transmit holding register. Both directions stay idle while the code is held, and writes to the data register are then ignored.
- R4: Control bits [4:2] select the character format: 0=7E2, 1=7O2, 2=7E1, 3=7O1, 4=8N2, 5=8N1, 6=8E1, 7=8O1. A frame is a low start bit, the data bits least significant first, the parity bit if any, and then the high stop bits. A character received in a 7-bit format reads back with bit 7 clear.
- R5: Status bit 6 (parity error) is set with the character when the received parity bit does not match the selected even or odd parity.
- R6: Status bit 4 (framing error) is set with the character when the first stop bit is sampled low.
- R7: Status bit 5 (overrun) is set when a character completes while status bit 0 (receive full) is still set. The new character is discarded and the held one is kept.
- R8: A read of the data register clears status bits 0, 4, 5 and 6.
- R9: Status bit 3 follows cts and status bit 2 follows dcd. While cts is high, status bit 1 (transmit empty) reads 0 and no new character starts.
- R10: Control bits [6:5]: code 2 drives rts high and codes 0, 1 and 3 drive it low. Code 1 enables the transmit interrupt. Code 3 holds txd low (break) from the next clock on.
- R11: irq and status bit 7 are high exactly when (control bit 7 and (receive full or overrun)) or (control bits [6:5]=1 and transmit empty).
- R12: At 16 and 64 clocks per bit the start bit is confirmed at half a bit period after the falling edge. A low pulse shorter than that produces no character.
- R13: When a data-register read falls in the same cycle as a character completes, the read returns the old character. Afterwards the new character is held with receive full set and no overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Host access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_rs | input | 1 | 0 = control/status, 1 = data |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data (status word or received character) |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line, registered |
| rts | output | 1 | Request-to-send level |
| dcd | input | 1 | Carrier-detect input, reported in status |
| cts | input | 1 | Clear-to-send input; high blocks transmission |
| irq | output | 1 | Interrupt request |

## Verification
A host read of the received character can land in the same clock edge as the receiver finishing the next character. Reading the character then clears receive full, while completion sets it again, so either order of these two updates changes the result. The bench provokes this at one clock per bit, where it drives the serial line itself and knows the exact cycle in which completion reaches the flags. It issues the read in that cycle, after a first character has been left unread. It then judges that the read returned the first character, that the second is held with receive full set, and that overrun stayed clear.

// File: rtl/asp_pkg.sv
`timescale 1ns/1ps
package asp_pkg;

  typedef struct packed {
    logic eight;     // 8 data bits, else 7
    logic par_en;    // parity bit present
    logic odd;       // odd parity when present
    logic two_stop;  // two stop bits
  } frame_fmt_t;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA} rx_state_t;

  function automatic frame_fmt_t decode_fmt(input logic [2:0] code);
    frame_fmt_t f;
    f.eight    = code[2];
    f.par_en   = !(code == 3'd4 || code == 3'd5);
    f.odd      = code[0];
    f.two_stop = (code == 3'd0 || code == 3'd1 || code == 3'd4);
    return f;
  endfunction

endpackage

// File: rtl/asp_tx.sv
`timescale 1ns/1ps
module asp_tx
  import asp_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic [CW-1:0] period_m1,
  input  frame_fmt_t    fmt,
  input  logic          start,
  input  logic [7:0]    data,
  output logic          line,
  output logic          busy
);
  localparam int FW = 12;

  logic [FW-1:0] sh_q, frame;
  logic [CW-1:0] cnt_q;
  logic [3:0]    left_q, nbits, nd;
  logic          pbit;

  always_comb begin
    nd    = fmt.eight ? 4'd8 : 4'd7;
    pbit  = (fmt.eight ? ^data : ^data[6:0]) ^ fmt.odd;
    frame = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (i < int'(nd)) frame[i+1] = data[i];
    if (fmt.par_en) frame[nd + 4'd1] = pbit;
    nbits = 4'd1 + nd + {3'b0, fmt.par_en} + (fmt.two_stop ? 4'd2 : 4'd1);
  end

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      busy   <= 1'b0;
      sh_q   <= '1;
      cnt_q  <= '0;
      left_q <= '0;
    end else if (!busy && start) begin
      busy   <= 1'b1;
      sh_q   <= frame;
      left_q <= nbits;
      cnt_q  <= period_m1;
    end else if (busy) begin
      if (cnt_q == '0) begin
        cnt_q  <= period_m1;
        sh_q   <= {1'b1, sh_q[FW-1:1]};
        left_q <= left_q - 4'd1;
        if (left_q == 4'd1) busy <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign line = busy ? sh_q[0] : 1'b1;

endmodule

// File: rtl/asp_rx.sv
`timescale 1ns/1ps
module asp_rx
  import asp_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic          rxd,
  input  logic [CW-1:0] period_m1,
  input  logic [CW-1:0] half_m1,
  input  frame_fmt_t    fmt,
  output logic          done,
  output logic [7:0]    data,
  output logic          perr,
  output logic          ferr
);
  rx_state_t     st_q;
  logic [CW-1:0] cnt_q;
  logic [3:0]    idx_q, last_idx;
  logic [9:0]    sh_q;
  logic [7:0]    dm;
  logic          pbit;

  always_comb begin
    last_idx = (fmt.eight ? 4'd8 : 4'd7) + {3'b0, fmt.par_en};
    dm       = fmt.eight ? sh_q[7:0] : {1'b0, sh_q[6:0]};
    pbit     = fmt.eight ? sh_q[8] : sh_q[7];
  end

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst || hold) begin
      st_q  <= RX_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      sh_q  <= '0;
      data  <= '0;
      perr  <= 1'b0;
      ferr  <= 1'b0;
    end else begin
      case (st_q)
        RX_IDLE: if (!rxd) begin
          idx_q <= '0;
          if (period_m1 == '0) begin
            st_q  <= RX_DATA;
            cnt_q <= '0;
          end else begin
            st_q  <= RX_START;
            cnt_q <= half_m1;
          end
        end
        RX_START: if (cnt_q == '0) begin
          st_q  <= rxd ? RX_IDLE : RX_DATA;
          cnt_q <= period_m1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        RX_DATA: if (cnt_q == '0) begin
          cnt_q       <= period_m1;
          sh_q[idx_q] <= rxd;
          idx_q       <= idx_q + 4'd1;
          if (idx_q == last_idx) begin
            st_q <= RX_IDLE;
            done <= 1'b1;
            data <= dm;
            perr <= fmt.par_en && (pbit != ((^dm) ^ fmt.odd));
            ferr <= !rxd;
          end
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= RX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/async_serial_port.sv
`timescale 1ns/1ps
module async_serial_port
  import asp_pkg::*;
#(
  parameter int DIV_MID  = 16,
  parameter int DIV_SLOW = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_en,
  input  logic       bus_wr,
  input  logic       bus_rs,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       rxd,
  output logic       txd,
  output logic       rts,
  input  logic       dcd,
  input  logic       cts,
  output logic       irq
);
  localparam int CW = $clog2(DIV_SLOW);

  logic [7:0]    ctl_q, tdr_q, rdr_q;
  logic          tdr_full_q, rx_full, rx_ovr, rx_ferr, rx_perr;
  logic          hold, wr_ctl, wr_dat, rd_dat, tx_load, tx_room;
  logic [CW-1:0] period_m1, half_m1;
  frame_fmt_t    fmt;
  logic          tx_line, tx_busy, rx_done, rx_pe, rx_fe;
  logic [7:0]    rx_byte;
  logic [7:0]    status;

  assign hold   = (ctl_q[1:0] == 2'b11);
  assign fmt    = decode_fmt(ctl_q[4:2]);
  assign wr_ctl = bus_en &  bus_wr & !bus_rs;
  assign wr_dat = bus_en &  bus_wr &  bus_rs;
  assign rd_dat = bus_en & !bus_wr &  bus_rs;

  always_comb begin
    case (ctl_q[1:0])
      2'b01:   begin period_m1 = CW'(DIV_MID - 1);  half_m1 = CW'(DIV_MID/2 - 1);  end
      2'b10:   begin period_m1 = CW'(DIV_SLOW - 1); half_m1 = CW'(DIV_SLOW/2 - 1); end
      default: begin period_m1 = '0;                half_m1 = '0;                  end
    endcase
  end

  assign tx_load = tdr_full_q & !tx_busy & !cts & !hold;
  assign tx_room = !tdr_full_q & !cts;

  asp_tx #(.CW(CW)) u_tx (
    .clk(clk), .rst(rst), .hold(hold), .period_m1(period_m1), .fmt(fmt),
    .start(tx_load), .data(tdr_q), .line(tx_line), .busy(tx_busy)
  );

  asp_rx #(.CW(CW)) u_rx (
    .clk(clk), .rst(rst), .hold(hold), .rxd(rxd), .period_m1(period_m1),
    .half_m1(half_m1), .fmt(fmt), .done(rx_done), .data(rx_byte),
    .perr(rx_pe), .ferr(rx_fe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q      <= 8'h03;
      tdr_q      <= '0;
      rdr_q      <= '0;
      tdr_full_q <= 1'b0;
      rx_full    <= 1'b0;
      rx_ovr     <= 1'b0;
      rx_ferr    <= 1'b0;
      rx_perr    <= 1'b0;
      txd        <= 1'b1;
    end else begin
      if (wr_ctl) ctl_q <= bus_wdata;
      txd <= (ctl_q[6:5] == 2'b11) ? 1'b0 : tx_line;
      if (hold) begin
        tdr_full_q <= 1'b0;
        rx_full    <= 1'b0;
        rx_ovr     <= 1'b0;
        rx_ferr    <= 1'b0;
        rx_perr    <= 1'b0;
      end else begin
        if (wr_dat) begin
          tdr_q      <= bus_wdata;
          tdr_full_q <= 1'b1;
        end else if (tx_load) begin
          tdr_full_q <= 1'b0;
        end
        if (rd_dat) begin
          rx_full <= 1'b0;
          rx_ovr  <= 1'b0;
          rx_ferr <= 1'b0;
          rx_perr <= 1'b0;
        end
        if (rx_done) begin
          if (rx_full && !rd_dat) begin
            rx_ovr <= 1'b1;
          end else begin
            rdr_q   <= rx_byte;
            rx_full <= 1'b1;
            rx_ferr <= rx_fe;
            rx_perr <= rx_pe;
          end
        end
      end
    end
  end

  assign irq       = (ctl_q[7] & (rx_full | rx_ovr)) | ((ctl_q[6:5] == 2'b01) & tx_room);
  assign rts       = (ctl_q[6:5] == 2'b10);
  assign status    = {irq, rx_perr, rx_ovr, rx_ferr, cts, dcd, tx_room, rx_full};
  assign bus_rdata = bus_rs ? rdr_q : status;

endmodule

// File: rtl/asp_checker.sv
`timescale 1ns/1ps
module asp_checker (
  input logic       clk,
  input logic       rst,
  input logic       cts,
  input logic       txd,
  input logic       irq,
  input logic       hold,
  input logic [7:0] ctl_q,
  input logic [7:0] rdr_q,
  input logic       tx_busy,
  input logic       rx_full,
  input logic       rx_ovr,
  input logic       rx_ferr,
  input logic       rx_perr,
  input logic       rd_dat,
  input logic       rx_done
);
  p_hold_idle_r3: assert property (@(posedge clk) disable iff (rst)
    hold && $past(hold) |-> !rx_full && !rx_ovr && !rx_ferr && !rx_perr && !tx_busy);

  p_cts_gate_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_busy) |-> !$past(cts));

  p_ovr_keeps_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_ovr) |-> $stable(rdr_q));

  p_read_clear_r8: assert property (@(posedge clk) disable iff (rst)
    rd_dat && !rx_done |=> !rx_full && !rx_ovr && !rx_ferr && !rx_perr);

  p_break_r10: assert property (@(posedge clk) disable iff (rst)
    ctl_q[6:5] == 2'b11 |=> !txd);

  p_irq_src_r11: assert property (@(posedge clk) disable iff (rst)
    irq |-> rx_full || rx_ovr || !cts);
endmodule

bind async_serial_port asp_checker u_chk (
  .clk(clk), .rst(rst), .cts(cts), .txd(txd), .irq(irq), .hold(hold),
  .ctl_q(ctl_q), .rdr_q(rdr_q), .tx_busy(tx_busy), .rx_full(rx_full),
  .rx_ovr(rx_ovr), .rx_ferr(rx_ferr), .rx_perr(rx_perr), .rd_dat(rd_dat),
  .rx_done(rx_done)
);

// File: tb/async_serial_port_tb.sv
`timescale 1ns/1ps
module async_serial_port_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_en = 1'b0, bus_wr = 1'b0, bus_rs = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       txd, rts, irq;
  logic       dcd = 1'b0, cts = 1'b0;
  logic       loop = 1'b1, bench_rx = 1'b1;
  logic       rxd_in;
  int         n_chk = 0, n_bad = 0;
  bit         finished = 0;

  always #2.5 clk = ~clk;
  assign rxd_in = loop ? txd : bench_rx;

  async_serial_port u_dut (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_wr(bus_wr), .bus_rs(bus_rs),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rxd(rxd_in), .txd(txd),
    .rts(rts), .dcd(dcd), .cts(cts), .irq(irq)
  );

  // {format code, data byte}
  localparam logic [10:0] VECS [8] = '{
    {3'd0, 8'h5A}, {3'd1, 8'h3C}, {3'd2, 8'h7F}, {3'd3, 8'h01},
    {3'd4, 8'hA5}, {3'd5, 8'h00}, {3'd6, 8'hC3}, {3'd7, 8'h96}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic rs, input logic [7:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b1; bus_rs = rs; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic rs, output logic [7:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b0; bus_rs = rs;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drive n bits LSB first, each per clocks long, last bit last_len long
  task automatic drive_frame(input logic [11:0] fr, input int n, input int per, input int last_len);
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      bench_rx = fr[i];
      repeat ((i == n - 1) ? last_len : per) @(negedge clk);
    end
    bench_rx = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, a;
    int lowc, minv;
    idle(3);
    rst = 1'b0;
    idle(2);
    // R1 reset state
    bus_read(0, r); chk("R1 status", r, 8'h02);
    chk("R1 txd", txd, 1); chk("R1 rts", rts, 0); chk("R1 irq", irq, 0);
    // R3 held idle under master reset: data write ignored
    bus_write(1, 8'h00);
    minv = 1;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (!txd) minv = 0; end
    chk("R3 txd idle in reset", minv, 1);
    bus_read(0, r); chk("R3 write ignored", r, 8'h02);

    // R4 table of formats, loopback at 16 clocks per bit
    for (int v = 0; v < 8; v++) begin
      logic [2:0] f;
      logic [7:0] d;
      f = VECS[v][10:8]; d = VECS[v][7:0];
      bus_write(0, {3'b000, f, 2'b01});
      bus_write(1, d);
      idle(300);
      bus_read(0, r); chk($sformatf("R4 status fmt%0d", f), r, 8'h03);
      bus_read(1, r); chk($sformatf("R4 data fmt%0d", f), r, f[2] ? d : {1'b0, d[6:0]});
    end

    // R2 start bit length at 16 and 64
    bus_write(0, 8'h15);
    bus_write(1, 8'hFF);
    for (int i = 0; i < 50 && txd; i++) @(negedge clk);
    lowc = 0;
    while (!txd && lowc < 200) begin lowc++; @(negedge clk); end
    chk("R2 start bit /16", lowc, 16);
    idle(250); bus_read(1, r);
    bus_write(0, 8'h16);
    bus_write(1, 8'hFF);
    for (int i = 0; i < 50 && txd; i++) @(negedge clk);
    lowc = 0;
    while (!txd && lowc < 200) begin lowc++; @(negedge clk); end
    chk("R2 start bit /64", lowc, 64);
    idle(800);
    bus_read(1, r); chk("R2 data /64", r, 8'hFF);

    // R7 overrun then R8 clear
    bus_write(0, 8'h15);
    bus_write(1, 8'h11); idle(250);
    bus_write(1, 8'h22); idle(250);
    bus_read(0, r); chk("R7 overrun status", r, 8'h23);
    bus_read(1, r); chk("R7 kept first", r, 8'h11);
    bus_read(0, r); chk("R8 cleared after read", r, 8'h02);

    // R5 parity error, 8E1, data 0x01 with parity bit 0
    loop = 1'b0;
    bus_write(0, 8'h19);
    drive_frame({1'b1, 1'b1, 1'b0, 8'h01, 1'b0}, 11, 16, 16);
    idle(20);
    bus_read(0, r); chk("R5 parity flag", r, 8'h43);
    bus_read(1, r); chk("R5 data", r, 8'h01);
    bus_read(0, r); chk("R8 parity cleared", r, 8'h02);

    // R6 framing error, 8N1, stop low
    bus_write(0, 8'h15);
    drive_frame({2'b11, 1'b0, 8'hA7, 1'b0}, 10, 16, 10);
    idle(40);
    bus_read(0, r); chk("R6 framing flag", r, 8'h13);
    bus_read(1, r); chk("R6 data", r, 8'hA7);

    // R12 short glitch rejected
    drive_frame(12'hFFE, 1, 4, 4);
    idle(300);
    bus_read(0, r); chk("R12 glitch ignored", r, 8'h02);

    // R9 cts gating, modem status
    loop = 1'b1;
    cts = 1'b1; dcd = 1'b1;
    idle(2);
    bus_read(0, r); chk("R9 status cts/dcd", r, 8'h0C);
    bus_write(1, 8'h55);
    minv = 1;
    for (int i = 0; i < 100; i++) begin @(negedge clk); if (!txd) minv = 0; end
    chk("R9 no start while cts", minv, 1);
    cts = 1'b0; dcd = 1'b0;
    idle(250);
    bus_read(1, r); chk("R9 sent after cts low", r, 8'h55);

    // R10 rts and break
    bus_write(0, 8'h55); idle(1);
    chk("R10 rts high", rts, 1);
    bus_write(0, 8'h75); idle(2);
    chk("R10 break", txd, 0); chk("R10 rts low in break", rts, 0);
    bus_write(0, 8'h15); idle(2);
    chk("R10 break released", txd, 1);
    idle(40); bus_read(1, r);

    // R11 interrupts
    bus_write(0, 8'h35); idle(1);
    chk("R11 tx irq", irq, 1);
    bus_read(0, r); chk("R11 status bit7", r[7], 1);
    cts = 1'b1; idle(1);
    chk("R11 no tx irq when cts", irq, 0);
    cts = 1'b0;
    bus_write(0, 8'h95);
    bus_write(1, 8'h3E); idle(250);
    chk("R11 rx irq", irq, 1);
    bus_read(1, r); idle(1);
    chk("R11 rx irq cleared", irq, 0);

    // R3 master reset clears flags
    bus_write(1, 8'h44); idle(250);
    bus_write(0, 8'h03); idle(2);
    bus_read(0, r); chk("R3 reset clears flags", r, 8'h02);

    // R13 read coincides with completion, one clock per bit
    loop = 1'b0;
    bus_write(0, 8'h14);
    drive_frame({2'b11, 8'h6B, 1'b0}, 10, 1, 1);
    idle(4);
    drive_frame({2'b11, 8'h9D, 1'b0}, 10, 1, 1);
    bus_en = 1'b1; bus_wr = 1'b0; bus_rs = 1'b1;
    #1 a = bus_rdata;
    @(negedge clk);
    bus_en = 1'b0;
    chk("R13 read returned old", a, 8'h6B);
    bus_read(0, r); chk("R13 status full no overrun", r, 8'h03);
    bus_read(1, r); chk("R13 new char held", r, 8'h9D);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule